// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block decides which of fourteen interrupt sources an 8051-style CPU core should service next, and where the service routine starts. Every source has a request flag, an enable bit and a priority bit. A global enable gates all sources. Source 0 is the power-fail source and always sits on the top level. Every other source sits on the high level or the low level, chosen by its priority bit. Among pending sources on the same level, the lower index wins. The service address is 03h plus eight times the source index.

The block keeps one in-service bit per level. A new request is offered only if its level is strictly above the highest level currently in service. The CPU accepts the offered vector with an `ack` pulse. It signals the end of a routine with a `reti` pulse, which releases the highest in-service level.

Some flags are cleared by hardware when vectoring happens. Sources 2 and 4 are cleared always. Sources 1 and 3 are cleared when their pin works in edge mode. Sources 1 and 3 are driven by two active-low external pins that can work in edge mode or level mode. Arbitration is paused briefly after a return or a configuration write, so that a stale winner is never offered.

Top module: `intc_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `vec_req` is 0, `in_service` is 000 and `flags` is all zero.
- R2: A source is pending when its flag, its `src_en` bit and `glob_en` are all 1. Without a pending, eligible source, `vec_req` stays 0.
- R3: The level of source 0 is 2, whatever its priority bit. The level of any other source is 1 when its `src_hi` bit is 1 and 0 otherwise. The highest pending level wins.
- R4: When several pending sources share the winning level, the lowest source index wins.
- R5: `vec_src` gives the winner's index, and `vec_addr` equals 03h + 8 × index. For example, index 5 gives 2Bh and index 13 gives 6Bh.
- R6: A source is offered only if its level is strictly above the highest level set in `in_service`. Bit n of `in_service` stands for level n.
- R7: `ack` while `vec_req` is 1 sets the `in_service` bit of the offered source's level. `ack` while `vec_req` is 0 has no effect.
- R8: `reti` clears the highest set bit of `in_service`. When no bit is set, it has no effect. When `reti` and an accepted `ack` fall in the same cycle, the clear applies to the old value, and the winner's level bit is then set.
- R9: On an accepted `ack`, the flag of source 2 or source 4 is cleared. The flag of source 1 or source 3 is cleared only when its pin is in edge mode. All other flags stay set.
- R10: A `sw_clr` bit clears its flag. A `raise` pulse in the same cycle as any clear of the same flag wins, and the flag stays 1.
- R11: `ext_n[0]` drives source 1 and `ext_n[1]` drives source 3. Each pin is synchronized through two flip-flops. In edge mode (`ext_edge` bit = 1), a high-to-low transition sets the flag, and the flag holds until it is cleared. `raise` bits 1 and 3 have no effect.
- R12: In level mode (`ext_edge` bit = 0), the flag equals the inverted synchronized pin. It appears after two clock edges and ignores `ack` and `sw_clr`.
- R13: A cycle with an accepted `ack`, a `reti` or a `cfg_wr` forces `vec_req` to 0 on the next edge. After `reti` or `cfg_wr`, the following edge also forces 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 14 | Per-source enable |
| src_hi | input | 14 | Per-source priority bit (1 = high level) |
| cfg_wr | input | 1 | Pulse marking a change of enable or priority settings |
| raise | input | 14 | Set pulses from peripherals |
| sw_clr | input | 14 | Software flag clear pulses |
| ext_n | input | 2 | Active-low external pins for sources 1 and 3 |
| ext_edge | input | 2 | Pin mode: 1 = edge, 0 = level |
| ack | input | 1 | CPU accepts the offered vector |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_req | output | 1 | Vector offered to the CPU |
| vec_addr | output | 8 | Service address of the offered source |
| vec_src | output | 4 | Index of the offered source |
| flags | output | 14 | Current request flags |
| in_service | output | 3 | One bit per level in service |

## Verification
The case that needs the most care is an accepted `ack` and a `reti` landing in the same cycle. The in-service bits then receive a clear and a set together, and the result must be the old value with its top bit removed and the winner's bit added. The bench provokes this while a low-level routine is running and a newly raised high-level source is being offered. The expected value is 010, and the result is compared both against that value and against the bench's cycle model. A second collision is a `raise` and a clear of the same flag in one cycle, where the flag must stay set.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC       = 14;
    localparam int NLVL       = 3;
    localparam int SRC_W      = $clog2(NSRC);
    localparam int LVL_W      = $clog2(NLVL);
    localparam int VEC_W      = 8;
    localparam int VEC_STRIDE = 8;
    localparam int NPIN       = 2;
    localparam logic [VEC_W-1:0] VEC_BASE = 8'h03;
    localparam int PF_SRC     = 0;

    typedef logic [SRC_W-1:0] src_idx_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic     valid;
        src_idx_t src;
    } grant_t;

    function automatic logic [VEC_W-1:0] vec_of(src_idx_t s);
        return VEC_BASE + VEC_W'(VEC_STRIDE * int'(s));
    endfunction

    // pin number driving a source, or -1 when the source has no pin
    function automatic int pin_of(int s);
        if (s == 1) return 0;
        if (s == 3) return 1;
        return -1;
    endfunction

    function automatic logic clears_on_vector(int s);
        return (s == 2) || (s == 4);
    endfunction

    function automatic lvl_t level_of(int s, logic hi);
        if (s == PF_SRC) return lvl_t'(NLVL - 1);
        return hi ? lvl_t'(1) : lvl_t'(0);
    endfunction
endpackage

// File: rtl/intc_pin_capture.sv
module intc_pin_capture (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic hw_ack,
    input  logic sw_clr,
    output logic flag
);
    // sh[0], sh[1]: synchronizer; sh[2]: previous synchronized value
    logic [2:0] sh;
    logic       latched;
    logic       fall;

    assign fall = sh[2] & ~sh[1];

    always_ff @(posedge clk) begin
        if (rst) sh <= 3'b111;
        else     sh <= {sh[1:0], pin_n};
    end

    always_ff @(posedge clk) begin
        if (rst || !edge_mode)      latched <= 1'b0;
        else if (fall)              latched <= 1'b1;
        else if (hw_ack || sw_clr)  latched <= 1'b0;
    end

    assign flag = edge_mode ? latched : ~sh[1];
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] hi,
    input  logic [NLVL-1:0] in_svc,
    output grant_t          grant
);
    int   ceiling;
    lvl_t best;
    lvl_t cand;

    always_comb begin
        ceiling = -1;
        for (int l = 0; l < NLVL; l++)
            if (in_svc[l]) ceiling = l;

        grant = '0;
        best  = '0;
        cand  = '0;
        // scan from the top index down so a lower index wins equal levels
        for (int i = NSRC - 1; i >= 0; i--) begin
            cand = level_of(i, hi[i]);
            if (pend[i] && (int'(cand) > ceiling) &&
                (!grant.valid || cand >= best)) begin
                grant.valid = 1'b1;
                grant.src   = src_idx_t'(i);
                best        = cand;
            end
        end
    end
endmodule

// File: rtl/intc_level_stack.sv
module intc_level_stack
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  lvl_t            push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] active
);
    logic [NLVL-1:0] top_mask;
    logic [NLVL-1:0] nxt;

    always_comb begin
        top_mask = '0;
        for (int l = 0; l < NLVL; l++)
            if (active[l]) top_mask = NLVL'(1) << l;
        nxt = active & ~(pop ? top_mask : '0);
        if (push) nxt[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) active <= '0;
        else     active <= nxt;
    end
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             glob_en,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic             cfg_wr,
    input  logic [NSRC-1:0]  raise,
    input  logic [NSRC-1:0]  sw_clr,
    input  logic [NPIN-1:0]  ext_n,
    input  logic [NPIN-1:0]  ext_edge,
    input  logic             ack,
    input  logic             reti,
    output logic             vec_req,
    output logic [VEC_W-1:0] vec_addr,
    output logic [SRC_W-1:0] vec_src,
    output logic [NSRC-1:0]  flags,
    output logic [NLVL-1:0]  in_service
);
    logic            take;
    logic            skip_q;
    logic            block;
    logic [NSRC-1:0] pend;
    grant_t          grant;
    src_idx_t        src_q;
    logic            req_q;
    lvl_t            take_lvl;

    assign take = ack & req_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int PIN = pin_of(i);
        logic hit;
        assign hit = take && (src_q == src_idx_t'(i));
        if (PIN >= 0) begin : g_pin
            logic unused_raise;
            assign unused_raise = raise[i];
            intc_pin_capture i_cap (
                .clk       (clk),
                .rst       (rst),
                .pin_n     (ext_n[PIN]),
                .edge_mode (ext_edge[PIN]),
                .hw_ack    (hit),
                .sw_clr    (sw_clr[i]),
                .flag      (flags[i])
            );
        end else begin : g_reg
            logic f_q;
            always_ff @(posedge clk) begin
                if (rst)                                         f_q <= 1'b0;
                else if (raise[i])                               f_q <= 1'b1;
                else if (sw_clr[i] || (hit && clears_on_vector(i))) f_q <= 1'b0;
            end
            assign flags[i] = f_q;
        end
    end

    assign pend = flags & src_en & {NSRC{glob_en}};

    intc_arbiter i_arb (
        .pend   (pend),
        .hi     (src_hi),
        .in_svc (in_service),
        .grant  (grant)
    );

    assign take_lvl = level_of(int'(src_q), src_hi[src_q]);

    intc_level_stack i_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_lvl (take_lvl),
        .pop      (reti),
        .active   (in_service)
    );

    assign block = take | reti | cfg_wr | skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= 1'b0;
            req_q  <= 1'b0;
            src_q  <= '0;
        end else begin
            skip_q <= reti | cfg_wr;
            req_q  <= ~block & grant.valid;
            if (!block) src_q <= grant.src;
        end
    end

    assign vec_req  = req_q;
    assign vec_src  = src_q;
    assign vec_addr = vec_of(src_q);
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             reti,
    input logic             cfg_wr,
    input logic [NSRC-1:0]  src_hi,
    input logic [NSRC-1:0]  raise,
    input logic             vec_req,
    input logic [VEC_W-1:0] vec_addr,
    input logic [SRC_W-1:0] vec_src,
    input logic [NSRC-1:0]  flags,
    input logic [NLVL-1:0]  in_service
);
    logic [LVL_W-1:0] offer_lvl;
    assign offer_lvl = (vec_src == '0) ? LVL_W'(NLVL - 1) : LVL_W'(src_hi[vec_src]);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!vec_req && in_service == '0 && flags == '0));

    p_addr_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (vec_addr[2:0] == 3'b011 && vec_addr <= 8'h6B));

    p_nest_strict_r6: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> ((in_service >> offer_lvl) == '0));

    p_push_level_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && vec_req && !reti) |=> (in_service != '0));

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (reti && in_service == '0 && !(ack && vec_req)) |=> (in_service == '0));

    p_timer_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ack && vec_req && vec_src == SRC_W'(2) && !raise[2]) |=> !flags[2]);

    p_gap_after_event_r13: assert property (@(posedge clk) disable iff (rst)
        (reti || cfg_wr) |=> (!vec_req ##1 !vec_req));
endmodule

bind intc_core intc_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .reti       (reti),
    .cfg_wr     (cfg_wr),
    .src_hi     (src_hi),
    .raise      (raise),
    .vec_req    (vec_req),
    .vec_addr   (vec_addr),
    .vec_src    (vec_src),
    .flags      (flags),
    .in_service (in_service)
);

// File: tb/test_intc_core.sv
`timescale 1ns/1ps
module test_intc_core;
    localparam int N = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic glob_en = 1'b0;
    logic [N-1:0] src_en = '0, src_hi = '0, raise = '0, sw_clr = '0;
    logic cfg_wr = 1'b0, ack = 1'b0, reti = 1'b0;
    logic [1:0] ext_n = 2'b11, ext_edge = 2'b01;
    logic vec_req;
    logic [7:0] vec_addr;
    logic [3:0] vec_src;
    logic [N-1:0] flags;
    logic [2:0] in_service;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    bit m_flag [N];
    bit m_lat [2];
    bit m_sh [2][3];
    bit m_isv [3];
    bit m_vreq, m_skip;
    int m_vsrc;

    always #4 clk = ~clk;

    intc_core i_intc_core (
        .clk(clk), .rst(rst), .glob_en(glob_en), .src_en(src_en), .src_hi(src_hi),
        .cfg_wr(cfg_wr), .raise(raise), .sw_clr(sw_clr), .ext_n(ext_n),
        .ext_edge(ext_edge), .ack(ack), .reti(reti), .vec_req(vec_req),
        .vec_addr(vec_addr), .vec_src(vec_src), .flags(flags), .in_service(in_service)
    );

    function automatic int pin_idx(int s);
        return (s == 1) ? 0 : (s == 3) ? 1 : -1;
    endfunction

    function automatic int lvl(int s);
        if (s == 0) return 2;
        return src_hi[s] ? 1 : 0;
    endfunction

    function automatic bit mflag(int s);
        int p = pin_idx(s);
        if (p < 0) return m_flag[s];
        return ext_edge[p] ? m_lat[p] : !m_sh[p][1];
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        bit nf [N];
        bit nl [2];
        bit ns [2][3];
        bit ni [3];
        int top, best, p;
        bit take;
        top = -1;
        for (int l = 0; l < 3; l++) if (m_isv[l]) top = l;
        best = -1;
        for (int i = 0; i < N; i++)
            if (mflag(i) && src_en[i] && glob_en && lvl(i) > top)
                if (best < 0 || lvl(i) > lvl(best)) best = i;
        take = ack && m_vreq;
        for (int i = 0; i < N; i++) begin
            nf[i] = m_flag[i];
            if (raise[i]) nf[i] = 1;
            else if (sw_clr[i] || (take && m_vsrc == i && (i == 2 || i == 4))) nf[i] = 0;
        end
        for (int k = 0; k < 2; k++) begin
            p = (k == 0) ? 1 : 3;
            ns[k][0] = ext_n[k]; ns[k][1] = m_sh[k][0]; ns[k][2] = m_sh[k][1];
            if (!ext_edge[k]) nl[k] = 0;
            else if (m_sh[k][2] && !m_sh[k][1]) nl[k] = 1;
            else if ((take && m_vsrc == p) || sw_clr[p]) nl[k] = 0;
            else nl[k] = m_lat[k];
        end
        for (int l = 0; l < 3; l++) ni[l] = m_isv[l];
        if (reti && top >= 0) ni[top] = 0;
        if (take) ni[lvl(m_vsrc)] = 1;
        @(posedge clk);
        #1;
        if (rst) begin
            for (int i = 0; i < N; i++) m_flag[i] = 0;
            for (int k = 0; k < 2; k++) begin
                m_lat[k] = 0;
                for (int j = 0; j < 3; j++) m_sh[k][j] = 1;
            end
            for (int l = 0; l < 3; l++) m_isv[l] = 0;
            m_vreq = 0; m_skip = 0; m_vsrc = 0;
        end else begin
            m_flag = nf; m_lat = nl; m_sh = ns; m_isv = ni;
            m_vreq = !(take || reti || cfg_wr || m_skip) && best >= 0;
            if (!(take || reti || cfg_wr || m_skip)) m_vsrc = (best < 0) ? 0 : best;
            m_skip = reti || cfg_wr;
        end
        // per-cycle comparison against the model
        chk("R2 R13 vec_req", vec_req, m_vreq);
        if (m_vreq) chk("R5 vec_addr", vec_addr, 3 + 8 * m_vsrc);
        chk("R7 R8 in_service", in_service, {m_isv[2], m_isv[1], m_isv[0]});
        for (int i = 0; i < N; i++) chk("R9 R10 flag", flags[i], mflag(i));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic pulse_clear();
        raise = '0; sw_clr = '0; ack = 0; reti = 0; cfg_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #2;
        idle(3);
        rst = 0;
        step();
        chk("R1 vec_req", vec_req, 0);
        chk("R1 flags", flags, 0);
        chk("R1 in_service", in_service, 0);

        glob_en = 1; src_en = '1; cfg_wr = 1; step(); pulse_clear();
        raise[5] = 1; raise[7] = 1; step(); pulse_clear();
        idle(4);
        chk("R4 tie lower index", vec_addr, 8'h2B);

        src_hi[9] = 1; cfg_wr = 1; step(); pulse_clear();
        raise[9] = 1; step(); pulse_clear();
        idle(4);
        chk("R3 high level wins", vec_addr, 8'h4B);
        ack = 1; step(); pulse_clear(); idle(3);
        chk("R7 level1 in service", in_service, 3'b010);
        chk("R6 equal level waits", vec_req, 0);
        chk("R9 flag 9 kept", flags[9], 1);

        raise[0] = 1; step(); pulse_clear(); idle(4);
        chk("R3 power-fail top", vec_addr, 8'h03);
        ack = 1; step(); pulse_clear(); idle(2);
        chk("R7 level2 nested", in_service, 3'b110);

        sw_clr[0] = 1; sw_clr[9] = 1; step(); pulse_clear();
        reti = 1; step(); pulse_clear(); idle(3);
        chk("R8 reti pops top", in_service, 3'b010);
        reti = 1; step(); pulse_clear(); idle(3);
        chk("R8 reti pops last", in_service, 3'b000);
        raise[2] = 1; step(); pulse_clear(); idle(4);
        chk("R4 timer0 first", vec_addr, 8'h13);
        ack = 1; step(); pulse_clear(); idle(2);
        chk("R9 timer0 hw clear", flags[2], 0);
        chk("R7 level0 in service", in_service, 3'b001);
        chk("R6 low waits", vec_req, 0);

        src_hi[5] = 1; cfg_wr = 1; step(); pulse_clear(); idle(4);
        chk("R6 higher nests", vec_addr, 8'h2B);
        ack = 1; reti = 1; step(); pulse_clear(); idle(2);
        chk("R8 reti with ack", in_service, 3'b010);

        raise[11] = 1; sw_clr[11] = 1; step(); pulse_clear(); step();
        chk("R10 set beats clear", flags[11], 1);
        sw_clr[11] = 1; step(); pulse_clear();
        chk("R10 software clear", flags[11], 0);

        ack = 1; step(); pulse_clear(); idle(2);
        chk("R7 ack without request", in_service, 3'b010);

        sw_clr = '1; step(); pulse_clear();
        reti = 1; step(); pulse_clear(); idle(2);
        reti = 1; step(); pulse_clear(); idle(2);
        chk("R8 reti when empty", in_service, 3'b000);

        raise[1] = 1; raise[3] = 1; step(); pulse_clear(); idle(3);
        chk("R11 raise ignored src1", flags[1], 0);
        chk("R11 raise ignored src3", flags[3], 0);
        ext_n[0] = 0; step(); idle(4);
        chk("R11 edge sets flag", flags[1], 1);
        ext_n[0] = 1; idle(4);
        chk("R11 edge flag holds", flags[1], 1);
        chk("R5 vector of src1", vec_addr, 8'h0B);
        ack = 1; step(); pulse_clear(); idle(2);
        chk("R9 edge flag cleared", flags[1], 0);
        reti = 1; step(); pulse_clear(); idle(3);

        ext_n[1] = 0; step();
        chk("R12 one edge not yet", flags[3], 0);
        step();
        chk("R12 level follows pin", flags[3], 1);
        idle(4);
        chk("R5 vector of src3", vec_addr, 8'h1B);
        ack = 1; step(); pulse_clear(); idle(2);
        chk("R12 ack leaves level flag", flags[3], 1);
        sw_clr[3] = 1; step(); pulse_clear();
        chk("R12 clear leaves level flag", flags[3], 1);
        ext_n[1] = 1; idle(3);
        chk("R12 pin released", flags[3], 0);
        reti = 1; step(); pulse_clear(); idle(3);

        glob_en = 0; cfg_wr = 1; step(); pulse_clear();
        raise[6] = 1; step(); pulse_clear(); idle(4);
        chk("R2 global disable", vec_req, 0);
        glob_en = 1; cfg_wr = 1; step(); pulse_clear(); idle(4);
        chk("R2 global enable", vec_addr, 8'h33);
        cfg_wr = 1; step(); pulse_clear();
        chk("R13 gap first", vec_req, 0);
        step();
        chk("R13 gap second", vec_req, 0);
        step();
        chk("R13 resumes", vec_req, 1);
        src_en[6] = 0; cfg_wr = 1; step(); pulse_clear(); idle(4);
        chk("R2 source disable", vec_req, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule